// File: doc/BRIEF.md
# Pulse-Position Bit Demodulator with 24-bit Parity Check

This block turns a stream of magnitude samples into a checked 112-bit message. Samples arrive one per clock at four times the bit rate. A timing controller that has already found the preamble raises a one-cycle start strobe, and the sample in that same cycle is the first sample of bit 0. From then on an internal phase counter splits every bit into two halves of two samples each. It adds up the energy in each half, and the larger half decides the bit value.

While the bits arrive, a serial 24-bit cyclic redundancy register absorbs the first 88 of them. The register then freezes for the final 24 bits, so that its remainder can be compared with those bits directly. A frame whose remainder matches is held back for one message length and then sent out as seven 16-bit words on consecutive cycles, with a valid flag. A frame that does not match is dropped without a trace on the outputs. Start strobes are not acted on while a frame is being received, held or sent.

Top module: `ppm_crc_demod`

## Requirements
- R1: During reset and after it, `msg_word_valid` is low and the block waits for a start strobe.
- R2: Each bit spans four samples. The sample present in the cycle where `frame_start` is accepted is sample 0 of bit 0, and bit k uses the samples from cycles 4k to 4k+3 after it.
- R3: A bit is 1 when the sum of its first two samples is strictly greater than the sum of its last two samples. Otherwise it is 0, and that includes equal sums.
- R4: The parity register starts at zero and absorbs bits 0 to 87, earliest first, as a shift-left register with generator polynomial 0x1FFF409. The feedback is the incoming bit XOR register bit 23, and when the feedback is 1 the register is XORed with 0xFFF409.
- R5: The parity register does not change during bits 88 to 111. The frame passes only when the register equals those 24 received bits, with bit 88 as the most significant.
- R6: A passing frame is emitted as exactly 7 words on consecutive cycles. Word i holds received bits 16i to 16i+15, with the earliest bit in bit 15.
- R7: The first output word appears 896 cycles after the start cycle: 448 cycles of reception plus a 448-cycle hold.
- R8: A failing frame produces no valid word, and the block returns to waiting so that the next start strobe begins a new frame normally.
- R9: A start strobe is ignored while a frame is being received, held or emitted. The frame in progress is neither restarted nor corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that marks sample 0 of bit 0 |
| mag_sample | input | 8 | Unsigned magnitude sample |
| msg_word | output | 16 | Output word of the checked message |
| msg_word_valid | output | 1 | High during the 7 beats of a passing frame |

## Verification
The frames are driven with three sample shapes. Clean, well-separated pulses check the basic slicing. A shape where the two halves differ by exactly one count catches an off-by-one in the half-sums or in which samples go into each half. A shape where every 0 bit has equal halves shows that a tie resolves to 0. The messages include all-zero data, all-one data and several pseudo-random patterns, each carrying a correctly computed parity field, so any error in the polynomial, the feed order or the freeze point causes a false rejection. A flipped parity bit and a flipped data bit must both suppress the output. A pass after a rejected frame shows recovery, and stray start strobes during reception and during the hold show that an in-flight frame is left alone.

// File: rtl/ppm_demod_pkg.sv
package ppm_demod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_HOLD = 2'd2,
    ST_EMIT = 2'd3
  } dem_state_e;

  // Low 24 bits of generator 0x1FFF409 (x^24 term implied)
  localparam logic [23:0] PARITY_POLY = 24'hFFF409;
endpackage

// File: rtl/ppm_bit_slicer.sv
module ppm_bit_slicer #(
  parameter int SAMPLE_W = 8,
  parameter int SPB      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                align,
  input  logic                active,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                bit_strobe,
  output logic                bit_val
);
  localparam int HALF  = SPB / 2;
  localparam int PH_W  = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int SUM_W = SAMPLE_W + $clog2(HALF + 1);

  logic [PH_W-1:0]  phase, cur_ph;
  logic [SUM_W-1:0] sum_early, sum_late, early_next, late_next;
  logic             run, in_early;

  assign run = align | active;

  always_comb begin
    cur_ph     = align ? '0 : phase;
    in_early   = cur_ph < PH_W'(HALF);
    early_next = ((cur_ph == '0) ? '0 : sum_early) + SUM_W'(sample);
    late_next  = ((cur_ph == PH_W'(HALF)) ? '0 : sum_late) + SUM_W'(sample);
    bit_strobe = run && (cur_ph == PH_W'(SPB - 1));
    bit_val    = sum_early > late_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      sum_early <= '0;
      sum_late  <= '0;
    end else if (run) begin
      phase <= (cur_ph == PH_W'(SPB - 1)) ? '0 : cur_ph + 1'b1;
      if (in_early) sum_early <= early_next;
      else          sum_late  <= late_next;
    end
  end
endmodule

// File: rtl/ppm_crc_serial.sv
module ppm_crc_serial #(
  parameter int               CRC_W = 24,
  parameter logic [CRC_W-1:0] POLY  = 24'hFFF409
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             feed,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc
);
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r,
                                                 input logic b);
    logic fb;
    fb = b ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (feed)  crc <= crc_step(crc, bit_in);
  end
endmodule

// File: rtl/ppm_word_packer.sv
module ppm_word_packer #(
  parameter int MSG_BITS = 112,
  parameter int WORD_W   = 16,
  parameter int IDX_W    = 3
) (
  input  logic [MSG_BITS-1:0] msg,
  input  logic [IDX_W-1:0]    idx,
  output logic [WORD_W-1:0]   word
);
  logic [MSG_BITS-1:0] shifted;

  always_comb begin
    shifted = msg << (int'(idx) * WORD_W);
    word    = shifted[MSG_BITS-1 -: WORD_W];
  end
endmodule

// File: rtl/ppm_crc_demod.sv
module ppm_crc_demod #(
  parameter int SAMPLE_W    = 8,
  parameter int SPB         = 4,
  parameter int MSG_BITS    = 112,
  parameter int CRC_W       = 24,
  parameter int WORD_W      = 16,
  parameter int RELEASE_DLY = 448
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic [SAMPLE_W-1:0] mag_sample,
  output logic [WORD_W-1:0]   msg_word,
  output logic                msg_word_valid
);
  import ppm_demod_pkg::*;

  localparam int DATA_BITS = MSG_BITS - CRC_W;
  localparam int NWORDS    = MSG_BITS / WORD_W;
  localparam int BC_W      = $clog2(MSG_BITS);
  localparam int WC_W      = $clog2(RELEASE_DLY + 1);
  localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1;

  dem_state_e          state;
  logic [BC_W-1:0]     bit_cnt;
  logic [WC_W-1:0]     hold_cnt;
  logic [IDX_W-1:0]    word_idx;
  logic [MSG_BITS-1:0] msg_sr;
  logic                frame_ok;

  // Named internal events
  logic             align, rx_active, bit_strobe, bit_val;
  logic             crc_hold, crc_feed, last_bit, crc_match;
  logic             release_go, last_word;
  logic [CRC_W-1:0] crc_val, parity_rx;

  assign align      = (state == ST_IDLE) && frame_start;
  assign rx_active  = (state == ST_RX);
  assign crc_hold   = rx_active && (bit_cnt >= BC_W'(DATA_BITS));
  assign crc_feed   = rx_active && bit_strobe && !crc_hold;
  assign last_bit   = rx_active && bit_strobe && (bit_cnt == BC_W'(MSG_BITS - 1));
  assign parity_rx  = {msg_sr[CRC_W-2:0], bit_val};
  assign crc_match  = (parity_rx == crc_val);
  assign release_go = (state == ST_HOLD) && (hold_cnt == WC_W'(RELEASE_DLY - 1));
  assign last_word  = (state == ST_EMIT) && (word_idx == IDX_W'(NWORDS - 1));

  ppm_bit_slicer #(.SAMPLE_W(SAMPLE_W), .SPB(SPB)) u_slicer (
    .clk       (clk),
    .rst_n     (rst_n),
    .align     (align),
    .active    (rx_active),
    .sample    (mag_sample),
    .bit_strobe(bit_strobe),
    .bit_val   (bit_val)
  );

  ppm_crc_serial #(.CRC_W(CRC_W), .POLY(PARITY_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (align),
    .feed  (crc_feed),
    .bit_in(bit_val),
    .crc   (crc_val)
  );

  ppm_word_packer #(.MSG_BITS(MSG_BITS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pack (
    .msg (msg_sr),
    .idx (word_idx),
    .word(msg_word)
  );

  assign msg_word_valid = (state == ST_EMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      hold_cnt <= '0;
      word_idx <= '0;
      msg_sr   <= '0;
      frame_ok <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (align) begin
            state   <= ST_RX;
            bit_cnt <= '0;
          end
        end
        ST_RX: begin
          if (bit_strobe) begin
            msg_sr  <= {msg_sr[MSG_BITS-2:0], bit_val};
            bit_cnt <= bit_cnt + 1'b1;
            if (last_bit) begin
              frame_ok <= crc_match;
              hold_cnt <= '0;
              state    <= crc_match ? ST_HOLD : ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          hold_cnt <= hold_cnt + 1'b1;
          if (release_go) begin
            word_idx <= '0;
            state    <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          word_idx <= word_idx + 1'b1;
          if (last_word) begin
            frame_ok <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppm_crc_demod_chk.sv
module ppm_crc_demod_chk #(
  parameter int CRC_W  = 24,
  parameter int NWORDS = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_start,
  input ppm_demod_pkg::dem_state_e state,
  input logic                     bit_strobe,
  input logic                     crc_hold,
  input logic [CRC_W-1:0]         crc_val,
  input logic                     last_bit,
  input logic                     word_valid,
  input logic                     frame_ok
);
  import ppm_demod_pkg::*;

  logic [3:0] vcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vcount <= '0;
    else if (word_valid) vcount <= vcount + 1'b1;
    else                 vcount <= '0;
  end

  // R1: leaving reset finds the block idle and silent
  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!word_valid && state == ST_IDLE));

  // R2: bit decisions are at least one sample apart while receiving
  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && bit_strobe) |=> !bit_strobe);

  // R5: parity register frozen during the parity bits
  assert_crc_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_hold |=> $stable(crc_val));

  // R8: no output from a frame that failed its check
  assert_valid_needs_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> frame_ok);

  // R6: bursts never exceed the word count
  assert_burst_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (vcount < 4'(NWORDS)));

  // R6: a burst ends only after the full word count
  assert_burst_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && $past(word_valid)) |-> ($past(vcount) == 4'(NWORDS - 1)));

  // R9: a start during reception does not disturb it
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX && frame_start && !last_bit) |=> (state == ST_RX));
endmodule

bind ppm_crc_demod ppm_crc_demod_chk #(.CRC_W(CRC_W), .NWORDS(NWORDS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .state      (state),
  .bit_strobe (bit_strobe),
  .crc_hold   (crc_hold),
  .crc_val    (crc_val),
  .last_bit   (last_bit),
  .word_valid (msg_word_valid),
  .frame_ok   (frame_ok)
);

// File: tb/ppm_crc_demod_test.sv
module ppm_crc_demod_test;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY    = 896;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [7:0]  mag_sample = '0;
  logic [15:0] msg_word;
  logic        msg_word_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ppm_crc_demod uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .mag_sample    (mag_sample),
    .msg_word      (msg_word),
    .msg_word_valid(msg_word_valid)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Parity by long division of data * x^24 by the generator (R4)
  function automatic logic [23:0] ref_parity(input logic [87:0] d);
    logic [111:0] w;
    w = {d, 24'h0};
    for (int i = 0; i < 88; i++)
      if (w[111-i]) w[111-i -: 25] = w[111-i -: 25] ^ 25'h1FFF409;
    return w[23:0];
  endfunction

  function automatic logic [87:0] gen_data(input int seed);
    logic [31:0] x;
    logic [95:0] acc;
    x = 32'(seed) ^ 32'h9E3779B9;
    for (int i = 0; i < 3; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      acc[i*32 +: 32] = x;
    end
    return acc[87:0];
  endfunction

  // Sample shapes: 0 clean, 1 one-count margin, 2 tie on zeros
  function automatic logic [7:0] pick(input logic b, input int mode, input int k, input int p);
    int z, s, v;
    z = k % 20;
    s = 100 + (k * 7) % 50;
    v = 0;
    case (mode)
      0: v = b ? ((p == 0) ? 180 : (p == 1) ? 170 : (p == 2) ? 12 : 5)
               : ((p == 0) ? 9 : (p == 1) ? 3 : (p == 2) ? 175 : 190);
      1: begin
        if (b) v = (p == 0) ? s : (p == 1) ? 60 : (p == 2) ? 59 + z : s - z;
        else   v = (p == 2) ? s : (p == 3) ? 60 : (p == 0) ? 59 + z : s - z;
      end
      default: begin
        if (b) v = (p == 2) ? 89 : 90;
        else   v = (p == 0 || p == 3) ? 50 + z : 70;
      end
    endcase
    return 8'(v);
  endfunction

  task automatic run_frame(input logic [111:0] m, input int mode, input bit poke,
                           input bit expect_ok, input string tag);
    int c0, first_seen, beats;
    logic [15:0] exp_w;
    @(negedge clk);
    c0 = cyc;
    for (int k = 0; k < 112; k++) begin
      for (int p = 0; p < 4; p++) begin
        frame_start = (k == 0 && p == 0) || (poke && (k == 40 || k == 100) && p == 2);
        mag_sample  = pick(m[111-k], mode, k, p);
        @(negedge clk);
      end
    end
    frame_start = 1'b0;
    mag_sample  = '0;
    first_seen  = -1;
    beats       = 0;
    for (int t = 0; t < 1000; t++) begin
      frame_start = poke && (t == 100);  // falls inside the hold window (R9)
      if (msg_word_valid) begin
        if (first_seen < 0) first_seen = cyc - c0;
        if (beats < 7) begin
          exp_w = m[111 - 16*beats -: 16];
          check(msg_word == exp_w, {"R6/R3 word ", tag}, msg_word, exp_w);
        end
        beats++;
      end
      @(negedge clk);
    end
    frame_start = 1'b0;
    if (expect_ok) begin
      check(first_seen == LATENCY, {"R7 latency ", tag}, first_seen, LATENCY);
      check(beats == 7, {"R6 beat count ", tag}, beats, 7);
    end else begin
      check(beats == 0, {"R8 rejected frame ", tag}, beats, 0);
    end
  endtask

  function automatic logic [111:0] make_msg(input logic [87:0] d);
    return {d, ref_parity(d)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [111:0] m;
    repeat (3) @(negedge clk);
    check(msg_word_valid == 1'b0, "R1 valid low in reset", msg_word_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(msg_word_valid == 1'b0, "R1 valid low after reset", msg_word_valid, 0);
    end

    // R4 all-zero data gives zero parity
    run_frame(make_msg(88'h0), 0, 1'b0, 1'b1, "zeros");
    // R2/R3 clean pulses, R4 pseudo-random parity
    run_frame(make_msg(gen_data(1)), 0, 1'b0, 1'b1, "rand clean");
    // R3 one-count margin
    run_frame(make_msg(gen_data(2)), 1, 1'b0, 1'b1, "rand margin");
    // R3 ties decode as zero
    run_frame(make_msg(gen_data(3)), 2, 1'b0, 1'b1, "rand tie");
    // R9 stray starts during reception and hold
    run_frame(make_msg({88{1'b1}}), 1, 1'b1, 1'b1, "ones poked");

    // R5 flipped parity bit must fail
    m = make_msg(gen_data(4));
    m[0] = ~m[0];
    run_frame(m, 0, 1'b0, 1'b0, "bad parity");
    // R4 flipped data bit must fail
    m = make_msg(gen_data(5));
    m[101] = ~m[101];
    run_frame(m, 1, 1'b0, 1'b0, "bad data");
    // R8 recovery after a rejected frame
    run_frame(make_msg(gen_data(6)), 1, 1'b0, 1'b1, "after fail");

    // Sweep across shapes and messages
    for (int s = 10; s < 19; s++)
      run_frame(make_msg(gen_data(s)), s % 3, (s % 4) == 0, 1'b1, "sweep");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule